// File: doc/BRIEF.md
# Successive-Approximation ADC Controller

This block is the digital half of an 8-bit successive-approximation analog-to-digital converter that sits on a small 8-bit register bus. Software sees two registers: a control/status register (interrupt enable, a conversion-complete flag, a start trigger, a power switch and a general oscillator-off bit) and a read-only conversion result. A start written while the converter is powered launches one conversion. The controller asserts a sample-and-hold strobe for one cycle. It then performs an 8-step binary search, MSB first. On each step it drives a trial code to the external DAC and reads back the external comparator bit.

When the search finishes, the result register is loaded and the completion flag rises. Only a new accepted start clears that flag. An interrupt request follows the flag whenever interrupts are enabled. A low-power stop input shuts the converter down. In wait mode the converter keeps running, and its interrupt is forwarded as a wake request. The oscillator-off bit is only held and driven out to the clock system.

The sequencer has three states. IDLE goes to SAMPLE on an accepted start. SAMPLE goes to TRIAL after one cycle, with the bit index at 7. TRIAL steps the index down each cycle and returns to IDLE after index 0, which is the completion event. An accepted start in any state goes to SAMPLE; this is the restart transition. Loss of enable in any state goes to IDLE; this is the abort transition.

Top module: `adc_sar_ctrl`

## Requirements
- R1: After reset the control register (address 0xD1) reads 0x40: completion flag set, all else clear; irq, wake_req, sample_hold, dac_code and osc_off are 0.
- R2: The start bit (bit 5) always reads 0. An accepted start (bit 5 and power bit 4 written as 1, stop_mode low) clears the completion flag (bit 6) on the same edge.
- R3: The completion flag rises exactly 9 cycles after the accepted start. The result register (address 0xD0) then holds the binary-search value, where each bit is kept if cmp_in is 1 (input at or above the trial code).
- R4: sample_hold is high in the first cycle after an accepted start. In the next cycle dac_code is 0x80, and later trial codes proceed MSB first.
- R5: Writing 0 to the completion flag has no effect; only an accepted start clears it.
- R6: A start accepted while a conversion runs abandons it. No completion occurs until 9 cycles after the new start.
- R7: irq is 1 exactly when interrupt enable (bit 7) and the completion flag are both 1.
- R8: With the power bit 0 a start is ignored (flag and result unchanged). Clearing the power bit mid-conversion aborts it, leaving the flag at 0.
- R9: While stop_mode is 1 a running conversion is aborted and starts are ignored. In wait mode a conversion still completes, and wake_req equals irq.
- R10: Bit 2 is a plain read/write bit driven on osc_off, with no effect on conversions.
- R11: Writes to the result address change nothing. Reserved bits 3, 1 and 0 always read 0.
- R12: The result register changes only on completion; aborted or restarted conversions leave the previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| cmp_in | input | 1 | Comparator: 1 when analog input >= dac_code |
| dac_code | output | 8 | Trial code to the DAC (0 outside trials) |
| sample_hold | output | 1 | Sample strobe to the sample-and-hold |
| stop_mode | input | 1 | Device in stop mode |
| wait_mode | input | 1 | Device in wait mode |
| irq | output | 1 | Conversion-complete interrupt request |
| wake_req | output | 1 | Wake request out of wait mode |
| osc_off | output | 1 | Held oscillator-off control bit |

## Verification
The bench converts full-scale, zero, alternating-bit and mid-scale inputs through a comparator model. A design that kept bits on the wrong comparator sense, or searched LSB first, would return wrong codes. Flag timing is probed one cycle before and at the completion edge, which catches an off-by-one sequencer. Restarts, power-off, stop-mode aborts and starts written while off are followed by reads of the flag and result. A design that loaded the result on an abort, let a zero write clear the flag, or honoured a start while unpowered would show a changed value.

// File: rtl/adc_sar_pkg.sv
package adc_sar_pkg;
    localparam int SAR_W  = 8;
    localparam int BUS_W  = 8;
    localparam int F_IE   = 7;
    localparam int F_EOC  = 6;
    localparam int F_GO   = 5;
    localparam int F_PWR  = 4;
    localparam int F_OSC  = 2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_TRIAL  = 2'd2
    } sar_state_e;
endpackage

// File: rtl/adc_ctrl_regs.sv
module adc_ctrl_regs
    import adc_sar_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter logic [7:0]  CTRL_ADDR = 8'hD1,
    parameter logic [7:0]  RES_ADDR  = 8'hD0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic              stop_mode,
    input  logic              conv_done,
    input  logic [SAR_W-1:0]  result,
    output logic [BUS_W-1:0]  rd_data,
    output logic              start_acc,
    output logic              seq_enable,
    output logic              ie_q,
    output logic              eoc_q,
    output logic              pwr_q,
    output logic              osc_q
);
    logic ctrl_wr;
    logic pwr_next;
    logic unused_wbits;

    assign ctrl_wr      = wr_en && (addr == ADDR_W'(CTRL_ADDR));
    assign pwr_next     = ctrl_wr ? wr_data[F_PWR] : pwr_q;
    assign start_acc    = ctrl_wr && wr_data[F_GO] && wr_data[F_PWR] && !stop_mode;
    assign seq_enable   = pwr_next && !stop_mode;
    assign unused_wbits = ^{wr_data[F_EOC], wr_data[3], wr_data[1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q  <= 1'b0;
            pwr_q <= 1'b0;
            osc_q <= 1'b0;
        end else if (ctrl_wr) begin
            ie_q  <= wr_data[F_IE];
            pwr_q <= wr_data[F_PWR];
            osc_q <= wr_data[F_OSC];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         eoc_q <= 1'b1;
        else if (start_acc) eoc_q <= 1'b0;
        else if (conv_done) eoc_q <= 1'b1;
    end

    always_comb begin
        rd_data = '0;
        if (addr == ADDR_W'(RES_ADDR)) begin
            rd_data = BUS_W'(result);
        end else if (addr == ADDR_W'(CTRL_ADDR)) begin
            rd_data[F_IE]  = ie_q;
            rd_data[F_EOC] = eoc_q;
            rd_data[F_PWR] = pwr_q;
            rd_data[F_OSC] = osc_q;
        end
    end
endmodule

// File: rtl/adc_sar_seq.sv
module adc_sar_seq
    import adc_sar_pkg::*;
#(
    parameter int W = SAR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         enable,
    input  logic         cmp_in,
    output logic [W-1:0] dac_code,
    output logic         sample_hold,
    output logic         done,
    output logic         idle,
    output logic [W-1:0] result
);
    localparam int IDX_W = (W > 1) ? $clog2(W) : 1;
    localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(W - 1);

    sar_state_e       state_q, state_d;
    logic [W-1:0]     acc_q, acc_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [W-1:0]     res_q;
    logic [W-1:0]     trial_bit;

    assign trial_bit = {{(W-1){1'b0}}, 1'b1} << idx_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            acc_q   <= '0;
            idx_q   <= IDX_TOP;
            res_q   <= '0;
        end else begin
            state_q <= state_d;
            acc_q   <= acc_d;
            idx_q   <= idx_d;
            if (done) res_q <= acc_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        acc_d   = acc_q;
        idx_d   = idx_q;
        if (start) begin
            state_d = ST_SAMPLE;
            acc_d   = '0;
            idx_d   = IDX_TOP;
        end else if (!enable) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_SAMPLE: begin
                    state_d = ST_TRIAL;
                    acc_d   = '0;
                    idx_d   = IDX_TOP;
                end
                ST_TRIAL: begin
                    if (cmp_in) acc_d = acc_q | trial_bit;
                    if (idx_q == '0) state_d = ST_IDLE;
                    else             idx_d   = idx_q - 1'b1;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        done        = (state_q == ST_TRIAL) && (idx_q == '0) && !start && enable;
        idle        = (state_q == ST_IDLE);
        sample_hold = (state_q == ST_SAMPLE);
        dac_code    = (state_q == ST_TRIAL) ? (acc_q | trial_bit) : '0;
        result      = res_q;
    end
endmodule

// File: rtl/adc_sar_ctrl.sv
module adc_sar_ctrl
    import adc_sar_pkg::*;
#(
    parameter int         ADDR_W    = 8,
    parameter logic [7:0] CTRL_ADDR = 8'hD1,
    parameter logic [7:0] RES_ADDR  = 8'hD0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              cmp_in,
    output logic [SAR_W-1:0]  dac_code,
    output logic              sample_hold,
    input  logic              stop_mode,
    input  logic              wait_mode,
    output logic              irq,
    output logic              wake_req,
    output logic              osc_off
);
    logic             start_acc, seq_enable, conv_done, seq_idle;
    logic             ie_q, eoc_q, pwr_q;
    logic [SAR_W-1:0] result;

    adc_ctrl_regs #(
        .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .RES_ADDR(RES_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
        .wr_data(bus_wdata), .stop_mode(stop_mode), .conv_done(conv_done),
        .result(result), .rd_data(bus_rdata), .start_acc(start_acc),
        .seq_enable(seq_enable), .ie_q(ie_q), .eoc_q(eoc_q),
        .pwr_q(pwr_q), .osc_q(osc_off)
    );

    adc_sar_seq #(.W(SAR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start_acc), .enable(seq_enable),
        .cmp_in(cmp_in), .dac_code(dac_code), .sample_hold(sample_hold),
        .done(conv_done), .idle(seq_idle), .result(result)
    );

    assign irq      = ie_q && eoc_q;
    assign wake_req = irq && wait_mode;
endmodule

// File: rtl/adc_sar_ctrl_checker.sv
module adc_sar_ctrl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start_acc,
    input logic       conv_done,
    input logic       seq_enable,
    input logic       seq_idle,
    input logic       eoc_q,
    input logic       pwr_q,
    input logic       stop_mode,
    input logic       sample_hold,
    input logic [7:0] dac_code,
    input logic [7:0] result
);
    a_r2_start_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
        start_acc |=> (!eoc_q && sample_hold));

    a_r3_flag_rises_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eoc_q) |-> $past(conv_done));

    a_r4_first_trial_msb: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_hold && !start_acc && seq_enable) |=> (dac_code == 8'h80));

    a_r5_flag_falls_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eoc_q) |-> $past(start_acc));

    a_r8_off_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_q && !start_acc) |=> seq_idle);

    a_r9_stop_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_mode |=> (seq_idle && !sample_hold));

    a_r12_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_done |=> $stable(result));
endmodule

bind adc_sar_ctrl adc_sar_ctrl_checker u_chk (
    .clk(clk), .rst_n(rst_n), .start_acc(start_acc), .conv_done(conv_done),
    .seq_enable(seq_enable), .seq_idle(seq_idle), .eoc_q(eoc_q),
    .pwr_q(pwr_q), .stop_mode(stop_mode), .sample_hold(sample_hold),
    .dac_code(dac_code), .result(result)
);

// File: tb/adc_sar_ctrl_bench.sv
module adc_sar_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_CTRL = 8'hD1;
    localparam logic [7:0] A_RES  = 8'hD0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_addr = A_CTRL;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       cmp_in;
    logic [7:0] dac_code;
    logic       sample_hold;
    logic       stop_mode = 1'b0;
    logic       wait_mode = 1'b0;
    logic       irq, wake_req, osc_off;
    logic [7:0] vin = 8'h00;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always_comb cmp_in = (vin >= dac_code);

    adc_sar_ctrl u_adc_sar_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_in(cmp_in),
        .dac_code(dac_code), .sample_hold(sample_hold), .stop_mode(stop_mode),
        .wait_mode(wait_mode), .irq(irq), .wake_req(wake_req), .osc_off(osc_off)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = A_CTRL;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
        bus_addr = A_CTRL;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // full conversion with timing probes; ctrl_val carries start and power
    task automatic t_convert(input logic [7:0] v, input logic [7:0] ctrl_val);
        logic [7:0] d;
        logic [7:0] base;
        base = ctrl_val & 8'h94;
        vin = v;
        wr(A_CTRL, ctrl_val);
        rd(A_CTRL, d); check("R2 flag cleared, start reads 0", d, base);
        check("R4 sample strobe", {7'd0, sample_hold}, 8'd1);
        cycles(1);
        check("R4 first trial code", dac_code, 8'h80);
        cycles(7);
        rd(A_CTRL, d); check("R3 flag not yet set", d, base);
        cycles(1);
        rd(A_CTRL, d); check("R3 flag set at 9 cycles", d, base | 8'h40);
        rd(A_RES, d);  check("R3 result", d, v);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        rd(A_CTRL, d); check("R1 ctrl reset", d, 8'h40);
        check("R1 outputs", {3'd0, irq, wake_req, sample_hold, osc_off, 1'b0}, 8'h00);
        check("R1 dac", dac_code, 8'h00);
    endtask

    task automatic t_flag_and_result_write;
        logic [7:0] d;
        wr(A_CTRL, 8'h10);
        rd(A_CTRL, d); check("R5 zero write keeps flag", d, 8'h50);
        wr(A_RES, 8'h33);
        rd(A_RES, d); check("R11 result read-only", d, 8'h5A);
        wr(A_CTRL, 8'h1B);
        rd(A_CTRL, d); check("R11 reserved read 0", d, 8'h50);
    endtask

    task automatic t_irq_wait;
        wr(A_CTRL, 8'h90);
        check("R7 irq with enable and flag", {7'd0, irq}, 8'd1);
        wait_mode = 1'b1;
        t_convert(8'h3C, 8'hB0);
        check("R9 wake in wait", {7'd0, wake_req}, 8'd1);
        check("R7 irq after completion", {7'd0, irq}, 8'd1);
        wait_mode = 1'b0;
        wr(A_CTRL, 8'h10);
        check("R7 irq off without enable", {7'd0, irq}, 8'd0);
    endtask

    task automatic t_restart;
        logic [7:0] d;
        vin = 8'h11;
        wr(A_CTRL, 8'h30);
        cycles(4);
        vin = 8'hC3;
        wr(A_CTRL, 8'h30);
        cycles(8);
        rd(A_CTRL, d); check("R6 no early completion", d, 8'h10);
        rd(A_RES, d);  check("R12 result held on restart", d, 8'h3C);
        cycles(1);
        rd(A_RES, d);  check("R6 restarted result", d, 8'hC3);
    endtask

    task automatic t_power;
        logic [7:0] d;
        wr(A_CTRL, 8'h00);
        rd(A_CTRL, d); check("R8 power off keeps flag", d, 8'h40);
        wr(A_CTRL, 8'h20);
        check("R8 no sample when off", {7'd0, sample_hold}, 8'd0);
        cycles(12);
        rd(A_CTRL, d); check("R8 start ignored when off", d, 8'h40);
        vin = 8'h77;
        wr(A_CTRL, 8'h30);
        cycles(3);
        wr(A_CTRL, 8'h00);
        cycles(12);
        rd(A_CTRL, d); check("R8 abort leaves flag 0", d, 8'h00);
        rd(A_RES, d);  check("R12 result held on power abort", d, 8'hC3);
    endtask

    task automatic t_stop;
        logic [7:0] d;
        vin = 8'h42;
        wr(A_CTRL, 8'h30);
        cycles(3);
        stop_mode = 1'b1;
        cycles(12);
        rd(A_CTRL, d); check("R9 stop aborts", d, 8'h10);
        rd(A_RES, d);  check("R12 result held on stop", d, 8'hC3);
        wr(A_CTRL, 8'h30);
        check("R9 start ignored in stop", {7'd0, sample_hold}, 8'd0);
        cycles(12);
        rd(A_CTRL, d); check("R9 no completion in stop", d, 8'h10);
        stop_mode = 1'b0;
        t_convert(8'h42, 8'h30);
    endtask

    task automatic t_osc;
        logic [7:0] d;
        wr(A_CTRL, 8'h14);
        check("R10 osc_off pin", {7'd0, osc_off}, 8'd1);
        rd(A_CTRL, d); check("R10 osc bit reads", d, 8'h54);
        t_convert(8'h7F, 8'h34);
        check("R10 osc kept", {7'd0, osc_off}, 8'd1);
        wr(A_CTRL, 8'h10);
        check("R10 osc clear", {7'd0, osc_off}, 8'd0);
    endtask

    initial begin
        cycles(3);
        rst_n = 1'b1;
        cycles(1);
        t_reset();
        t_convert(8'hFF, 8'h30);
        t_convert(8'h00, 8'h30);
        t_convert(8'hA5, 8'h30);
        t_convert(8'h80, 8'h30);
        t_convert(8'h5A, 8'h30);
        t_flag_and_result_write();
        t_irq_wait();
        t_restart();
        t_power();
        t_stop();
        t_osc();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule